// File: doc/BRIEF.md
# Frame-Linear Video Timing Generator

This block generates the raster timing for a video-mode display link. Software programs the geometry through a simple write port that shares the pixel clock. Horizontal timing is a line length plus a sync width, with an inclusive window of active columns. Vertical timing is not counted in lines. Every vertical quantity is an absolute pixel-clock offset from the start of the frame, and one frame-linear counter is compared against them. This lets the active window start part way through a line through a skew term.

While running, the block drives horizontal sync, vertical sync, a data-enable, and a one-cycle strobe at the first pixel of each frame. During the active window it forwards the incoming pixel. If the pixel source has nothing valid, it substitutes a programmable fill colour. All geometry writes land in staging registers, and they are copied to the working set only at a frame boundary or while the engine is stopped.

Top module: `frame_linear_vtg`

## Requirements
- R1: After reset, and whenever the engine is stopped, hsync, vsync, de and frame_start are low and pix_out is zero, whatever pix_valid and pix_data do.
- R2: Address 1 holds the line length in bits 31:16 and the sync width in bits 15:0. A column counter starts at 0 on enable and wraps after line length − 1. hsync is high while the column is below the sync width.
- R3: Address 2 holds the frame length in pixel clocks and address 3 the vertical sync length in pixel clocks. A frame counter starts at 0 on enable and wraps after frame length − 1. vsync is high while that counter is below the vertical sync length.
- R4: de is high exactly when two conditions both hold. The column must lie in the inclusive range set by address 4, with the first column in bits 15:0 and the last in bits 31:16. The frame counter must lie in the inclusive range from the start offset at address 5 to the end offset at address 6. A skew that puts the start offset mid-line is honoured.
- R5: frame_start is high for the single cycle in which the frame counter is 0, including the first cycle after enable.
- R6: When de is high, pix_out is pix_data if pix_valid is high. Otherwise it is the fill colour at address 7, which resets to 0xFF. When de is low, pix_out is zero.
- R7: A write to addresses 1 to 7 made while the engine runs leaves the current frame unchanged. It takes effect from the first cycle of the next frame.
- R8: Bit 0 of address 0 enables the engine. Clearing it forces all outputs low from the next cycle. Setting it again restarts at column 0, frame count 0, with a frame_start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and configuration clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Register address |
| cfg_wdata | input | 2*HW | Write data |
| pix_valid | input | 1 | Pixel source has data this cycle |
| pix_data | input | DW | Pixel from source |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Active-region data enable |
| frame_start | output | 1 | First-pixel-of-frame strobe |
| pix_out | output | DW | Pixel to the link |

## Verification
The raster is checked cycle by cycle against a model built from the programmed geometry. It is tried with a baseline frame, with a skewed start offset that falls inside the line's blanking columns, and with a sync-width change written mid-frame. The baseline frame separates errors in the column window from errors in the frame window. The skew case shows whether the vertical test is frame-linear rather than line-based. The mid-frame write tells a shadowed update apart from an immediate one. Pixel validity follows a repeating pattern, so each active frame contains both forwarded pixels and fill pixels. The stop and restart sequence shows whether the counters really return to zero.

// File: rtl/frame_linear_vtg.sv
module frame_linear_vtg #(
  parameter int HW = 16,
  parameter int DW = 24,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [2*HW-1:0] cfg_wdata,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          frame_start,
  output logic [DW-1:0] pix_out
);
  localparam int FW = 2 * HW;
  localparam logic [DW-1:0] FILL_RST = DW'(8'hFF);

  logic          run;
  logic [FW-1:0] s_hctl, s_fper, s_vsw, s_dh, s_vst, s_vend;
  logic [DW-1:0] s_fill;
  logic [FW-1:0] a_hctl, a_fper, a_vsw, a_dh, a_vst, a_vend;
  logic [DW-1:0] a_fill;
  logic [HW-1:0] col;
  logic [FW-1:0] fcnt;

  wire [HW-1:0] line_len  = a_hctl[FW-1:HW];
  wire [HW-1:0] hs_width  = a_hctl[HW-1:0];
  wire [HW-1:0] col_first = a_dh[HW-1:0];
  wire [HW-1:0] col_last  = a_dh[FW-1:HW];
  wire          end_line  = (col == line_len - HW'(1));
  wire          end_frame = (fcnt == a_fper - FW'(1));
  wire          load      = !run || end_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      s_hctl <= '0; s_fper <= '0; s_vsw <= '0; s_dh <= '0;
      s_vst  <= '0; s_vend <= '0; s_fill <= FILL_RST;
    end else if (cfg_we) begin
      case (cfg_addr)
        AW'(0): run    <= cfg_wdata[0];
        AW'(1): s_hctl <= cfg_wdata;
        AW'(2): s_fper <= cfg_wdata;
        AW'(3): s_vsw  <= cfg_wdata;
        AW'(4): s_dh   <= cfg_wdata;
        AW'(5): s_vst  <= cfg_wdata;
        AW'(6): s_vend <= cfg_wdata;
        default: s_fill <= cfg_wdata[DW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_hctl <= '0; a_fper <= '0; a_vsw <= '0; a_dh <= '0;
      a_vst  <= '0; a_vend <= '0; a_fill <= FILL_RST;
    end else if (load) begin
      a_hctl <= s_hctl; a_fper <= s_fper; a_vsw <= s_vsw; a_dh <= s_dh;
      a_vst  <= s_vst;  a_vend <= s_vend; a_fill <= s_fill;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      col  <= '0;
      fcnt <= '0;
    end else begin
      col  <= end_line  ? '0 : col + HW'(1);
      fcnt <= end_frame ? '0 : fcnt + FW'(1);
    end
  end

  assign hsync       = run && (col < hs_width);
  assign vsync       = run && (fcnt < a_vsw);
  assign de          = run && (col >= col_first) && (col <= col_last)
                           && (fcnt >= a_vst) && (fcnt <= a_vend);
  assign frame_start = run && (fcnt == '0);
  assign pix_out     = de ? (pix_valid ? pix_data : a_fill) : '0;

  assert_idle_counters_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!run) && !run) |-> (col == '0 && fcnt == '0));

  assert_col_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && col != '0) |-> (col == $past(col) + HW'(1)));

  assert_frame_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && fcnt != '0) |-> (fcnt == $past(fcnt) + FW'(1)));

  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && a_fper > FW'(1) && cfg_we == 1'b0) |=> !frame_start || !run);

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(end_frame)) |-> ($stable(a_hctl) && $stable(a_fper) && $stable(a_dh)));
endmodule

// File: tb/frame_linear_vtg_tb.sv
module frame_linear_vtg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic        hsync, vsync, de, frame_start;
  logic [23:0] pix_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int lp = 10, hpw = 2, first = 4, last = 7;
  int fper = 60, vsw = 10, vst = 20, vend = 49;
  int fill = 32'hFF;

  frame_linear_vtg u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_data(pix_data),
    .hsync(hsync), .vsync(vsync), .de(de), .frame_start(frame_start),
    .pix_out(pix_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog();
    wr(3'd1, {lp[15:0], hpw[15:0]});
    wr(3'd2, fper);
    wr(3'd3, vsw);
    wr(3'd4, {last[15:0], first[15:0]});
    wr(3'd5, vst);
    wr(3'd6, vend);
    wr(3'd7, fill);
  endtask

  task automatic quiet(input string req);
    pix_valid = 1'b1; pix_data = 24'hABCDEF;
    #1;
    chk({req, " hsync"}, hsync, 0);
    chk({req, " vsync"}, vsync, 0);
    chk({req, " de"}, de, 0);
    chk({req, " frame_start"}, frame_start, 0);
    chk({req, " pix_out"}, pix_out, 0);
  endtask

  // Checks ncyc cycles from cycle 0 of a run; optional sync-width write at wr_at.
  task automatic raster(input int ncyc, input int wr_at, input int new_hpw);
    int switch_at;
    switch_at = (wr_at < 0) ? ncyc + 1 : ((wr_at / fper) + 1) * fper;
    for (int n = 0; n < ncyc; n++) begin
      int c, kf, hp, dv;
      logic ede;
      c = n % lp; kf = n % fper;
      hp = (n >= switch_at) ? new_hpw : hpw;
      pix_valid = (n % 3) != 0;
      pix_data  = 24'(n * 7 + 1);
      if (n == wr_at) begin
        cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = {lp[15:0], new_hpw[15:0]};
      end else cfg_we = 1'b0;
      #1;
      ede = (c >= first) && (c <= last) && (kf >= vst) && (kf <= vend);
      dv  = ede ? (pix_valid ? n * 7 + 1 : fill) : 0;
      chk((n >= switch_at) ? "R7 hsync after shadow load" : "R2 hsync", hsync, c < hp);
      chk("R3 vsync", vsync, kf < vsw);
      chk("R4 de", de, ede);
      chk("R5 frame_start", frame_start, kf == 0);
      chk("R6 pix_out", pix_out, dv);
      @(negedge clk);
    end
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    quiet("R1 reset");
    prog();
    quiet("R1 configured but stopped");
  endtask

  task automatic t_basic();
    wr(3'd0, 1);
    raster(2 * fper, -1, 0);
  endtask

  task automatic t_stop_restart();
    wr(3'd0, 0);
    quiet("R8 stop");
    @(negedge clk);
    quiet("R1 stopped");
    wr(3'd0, 1);
    raster(fper + 10, -1, 0);
  endtask

  task automatic t_shadow();
    wr(3'd0, 0);
    @(negedge clk);
    wr(3'd0, 1);
    raster(2 * fper + 10, 30, 3);
    hpw = 3;
    wr(3'd0, 0);
  endtask

  task automatic t_skew_fill();
    vst = 23; vend = 52; fill = 32'h123456;
    prog();
    wr(3'd0, 1);
    raster(fper + 5, -1, 0);
    wr(3'd0, 0);
    quiet("R8 final stop");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_stop_restart();
    t_shadow();
    t_skew_fill();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule